// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Per-Access Write and Cache Policy

This block places a small direct-mapped data cache between a CPU request port and a word-wide main-memory port. The CPU sends one request at a time. Each request carries two page attribute bits: one makes the access skip the cache, the other makes a write go through to memory. Two global inputs can override both bits for every access: one turns caching off, the other forces write-through. The block therefore decides cacheability and write policy afresh for each access, from the global bits and the page bits together.

Each of the 16 lines holds 4 words of 32 bits, together with a tag, a valid bit and a dirty bit. A word address splits into three fields: tag (upper bits), line index (the next 4 bits) and word offset (the lowest 2 bits). Read and write misses fill the whole line. A dirty line that must leave the cache is written back first. A flush pulse walks the whole cache, writes back every dirty line and empties the cache.

Top module: `dcache_ctrl`

## Requirements
- R1: A cacheable read whose line is present returns the cached word in `rsp_rdata` and makes no memory access.
- R2: A cacheable write hit with write-back selected updates only the cached word and marks the line dirty, with no memory access. The response to any write carries `rsp_rdata` = 0.
- R3: A cacheable write hit with write-through selected updates the cached word and makes exactly one memory write of that address and data.
- R4: A cacheable read miss reads the 4 words of the line from memory in rising offset order, keeps them in the line, and returns the requested word.
- R5: A cacheable write miss first writes the word to memory and then fills the line from memory, so the filled line holds the written value and is clean.
- R6: When a miss lands on a line that is valid and dirty, the 4 old words are written to their own memory addresses before the first fill read.
- R7: When `cfg_cache_off` or `req_pg_nocache` is 1, the access makes exactly one memory read or write and neither reads nor changes the cache contents.
- R8: Write-through applies to an access when `cfg_force_wt` or `req_pg_wt` is 1. Otherwise write-back applies.
- R9: A pulse on `flush_req` writes back every valid dirty line in ascending index order and invalidates all lines. The block then raises `flush_done` for exactly one cycle.
- R10: `req_ready` is 0 while `flush_req` is 1 or a flush is pending or running. A request offered in the same cycle as `flush_req` is served only after `flush_done`.
- R11: Each accepted request produces exactly one `rsp_valid` pulse of one cycle.
- R12: A memory request holds `mem_addr`, `mem_write` and `mem_wdata` stable while `mem_valid` is 1 and `mem_ready` is 0. A memory read completes when `mem_rvalid` returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cache_off | input | 1 | Global switch: every access bypasses the cache |
| cfg_force_wt | input | 1 | Global switch: every write is write-through |
| flush_req | input | 1 | Pulse that starts a write-back-and-invalidate walk |
| flush_done | output | 1 | One-cycle pulse when the walk is complete |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address: tag, index and offset fields |
| req_wdata | input | 32 | Write data |
| req_pg_nocache | input | 1 | Page attribute: this access bypasses the cache |
| req_pg_wt | input | 1 | Page attribute: this write is write-through |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data returned |
| mem_rdata | input | 32 | Memory read data |

## Verification
A flush pulse and a new CPU request can arrive in the same cycle. The bench provokes this by raising `flush_req` and `req_valid` on the same falling edge, with a dirty line in the cache. It judges the result three ways. `req_ready` must be low in that very cycle. The request's response must come after the `flush_done` pulse. The read must then miss and refetch the line whose dirty data the flush wrote to memory. The memory model stalls `mem_ready` in a repeating pattern, so write-backs and fills also run across backpressure.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SW, S_WB, S_FILL_REQ, S_FILL_WAIT,
    S_BRD_REQ, S_BRD_WAIT, S_FL_CHK
  } cstate_t;

  typedef enum logic [2:0] {
    DIR_NONE, DIR_FILL, DIR_SET_DIRTY, DIR_CLR_DIRTY, DIR_INVAL
  } dir_op_t;

endpackage

// File: rtl/dcache_dir.sv
module dcache_dir
  import dcache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  dir_op_t          op,
  input  logic [TAG_W-1:0] op_tag,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (idx == IDX_W'(i)) begin
        unique case (op)
          DIR_FILL:      begin valid_q[i] <= 1'b1; dirty_q[i] <= 1'b0; end
          DIR_SET_DIRTY: dirty_q[i] <= 1'b1;
          DIR_CLR_DIRTY: dirty_q[i] <= 1'b0;
          DIR_INVAL:     begin valid_q[i] <= 1'b0; dirty_q[i] <= 1'b0; end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (idx == IDX_W'(i) && op == DIR_FILL) tag_q[i] <= op_tag;
    end

    // R2
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[i] |-> valid_q[i]);
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
  parameter int LINES = 16,
  parameter int WPL   = 4,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WPL)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [OFF_W-1:0] rd_off,
  output logic [DW-1:0]    rd_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data
);

  localparam int SLOTS = LINES * WPL;
  localparam int SL_W  = IDX_W + OFF_W;

  function automatic logic [SL_W-1:0] slot(input logic [IDX_W-1:0] i,
                                           input logic [OFF_W-1:0] o);
    return {i, o};
  endfunction

  logic [DW-1:0] word_q [SLOTS];

  always_ff @(posedge clk) begin
    if (we) word_q[slot(wr_idx, wr_off)] <= wr_data;
  end

  assign rd_data = word_q[slot(rd_idx, rd_off)];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WPL   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cache_off,
  input  logic          cfg_force_wt,
  input  logic          flush_req,
  output logic          flush_done,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_pg_nocache,
  input  logic          req_pg_wt,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  localparam int OFF_W = $clog2(WPL);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(input logic [AW-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [AW-1:0] word_addr(input logic [TAG_W-1:0] t,
      input logic [IDX_W-1:0] i, input logic [OFF_W-1:0] o);
    return {t, i, o};
  endfunction

  cstate_t          state;
  logic             q_write, q_byp, q_wt, q_miss;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_wdata;
  logic [OFF_W-1:0] cnt;
  logic [IDX_W-1:0] fl_idx;
  logic             fl_mode, fl_pend;

  logic [IDX_W-1:0] idx_sel;
  logic             dir_valid, dir_dirty;
  logic [TAG_W-1:0] dir_tag;
  dir_op_t          dir_op;
  logic [DW-1:0]    data_rd;
  logic             data_we;
  logic [OFF_W-1:0] data_rd_off, data_wr_off;
  logic [DW-1:0]    data_wr;

  // named internal events
  logic ev_hit, ev_victim_dirty, ev_last, ev_mem_acc;
  assign idx_sel         = fl_mode ? fl_idx : idx_of(q_addr);
  assign ev_hit          = dir_valid && (dir_tag == tag_of(q_addr));
  assign ev_victim_dirty = dir_valid && dir_dirty;
  assign ev_last         = (cnt == OFF_W'(WPL - 1));
  assign ev_mem_acc      = mem_valid && mem_ready;

  assign req_ready = (state == S_IDLE) && !fl_pend && !flush_req;

  dcache_dir #(.LINES(LINES), .TAG_W(TAG_W)) dir_i (
    .clk(clk), .rst_n(rst_n), .idx(idx_sel), .op(dir_op),
    .op_tag(tag_of(q_addr)), .line_valid(dir_valid),
    .line_dirty(dir_dirty), .line_tag(dir_tag)
  );

  dcache_data #(.LINES(LINES), .WPL(WPL), .DW(DW)) data_i (
    .clk(clk), .rd_idx(idx_sel), .rd_off(data_rd_off), .rd_data(data_rd),
    .we(data_we), .wr_idx(idx_sel), .wr_off(data_wr_off), .wr_data(data_wr)
  );

  assign data_rd_off = (state == S_WB) ? cnt : off_of(q_addr);
  assign data_wr_off = (state == S_FILL_WAIT) ? cnt : off_of(q_addr);
  assign data_wr     = (state == S_FILL_WAIT) ? mem_rdata : q_wdata;
  assign data_we     = (state == S_CHECK && !q_byp && ev_hit && q_write) ||
                       (state == S_FILL_WAIT && mem_rvalid);

  always_comb begin
    dir_op = DIR_NONE;
    unique case (state)
      S_CHECK:     if (!q_byp && ev_hit && q_write && !q_wt) dir_op = DIR_SET_DIRTY;
      S_FILL_WAIT: if (mem_rvalid && ev_last) dir_op = DIR_FILL;
      S_WB:        if (mem_ready && ev_last) dir_op = DIR_CLR_DIRTY;
      S_FL_CHK:    if (!ev_victim_dirty) dir_op = DIR_INVAL;
      default: ;
    endcase
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = q_addr;
    mem_wdata = q_wdata;
    unique case (state)
      S_WB: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = word_addr(dir_tag, idx_sel, cnt);
        mem_wdata = data_rd;
      end
      S_FILL_REQ: begin
        mem_valid = 1'b1;
        mem_addr  = word_addr(tag_of(q_addr), idx_of(q_addr), cnt);
      end
      S_SW:      begin mem_valid = 1'b1; mem_write = 1'b1; end
      S_BRD_REQ: mem_valid = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q_write <= 1'b0; q_byp <= 1'b0; q_wt <= 1'b0; q_miss <= 1'b0;
      q_addr <= '0; q_wdata <= '0; cnt <= '0;
      fl_idx <= '0; fl_mode <= 1'b0; fl_pend <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; flush_done <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      flush_done <= 1'b0;
      if (flush_req && state != S_IDLE) fl_pend <= 1'b1;
      unique case (state)
        S_IDLE:
          if (flush_req || fl_pend) begin
            fl_pend <= 1'b0; fl_mode <= 1'b1; fl_idx <= '0; state <= S_FL_CHK;
          end else if (req_valid) begin
            q_write <= req_write; q_addr <= req_addr; q_wdata <= req_wdata;
            q_byp   <= cfg_cache_off || req_pg_nocache;
            q_wt    <= cfg_force_wt || req_pg_wt;
            state   <= S_CHECK;
          end
        S_CHECK: begin
          rsp_rdata <= '0;
          q_miss    <= !ev_hit;
          cnt       <= '0;
          if (q_byp) state <= q_write ? S_SW : S_BRD_REQ;
          else if (ev_hit) begin
            if (!q_write) begin
              rsp_rdata <= data_rd; rsp_valid <= 1'b1; state <= S_IDLE;
            end else if (q_wt) state <= S_SW;
            else begin rsp_valid <= 1'b1; state <= S_IDLE; end
          end else if (q_write) state <= S_SW;
          else state <= ev_victim_dirty ? S_WB : S_FILL_REQ;
        end
        S_SW:
          if (mem_ready) begin
            if (q_byp || !q_miss) begin rsp_valid <= 1'b1; state <= S_IDLE; end
            else state <= ev_victim_dirty ? S_WB : S_FILL_REQ;
          end
        S_WB:
          if (mem_ready) begin
            cnt <= cnt + 1'b1;
            if (ev_last) begin
              cnt <= '0; state <= fl_mode ? S_FL_CHK : S_FILL_REQ;
            end
          end
        S_FILL_REQ: if (mem_ready) state <= S_FILL_WAIT;
        S_FILL_WAIT:
          if (mem_rvalid) begin
            if (!q_write && cnt == off_of(q_addr)) rsp_rdata <= mem_rdata;
            cnt <= cnt + 1'b1;
            if (ev_last) begin
              cnt <= '0; rsp_valid <= 1'b1; state <= S_IDLE;
            end else state <= S_FILL_REQ;
          end
        S_BRD_REQ: if (mem_ready) state <= S_BRD_WAIT;
        S_BRD_WAIT:
          if (mem_rvalid) begin
            rsp_rdata <= mem_rdata; rsp_valid <= 1'b1; state <= S_IDLE;
          end
        S_FL_CHK:
          if (ev_victim_dirty) begin cnt <= '0; state <= S_WB; end
          else if (fl_idx == IDX_W'(LINES - 1)) begin
            fl_mode <= 1'b0; flush_done <= 1'b1; state <= S_IDLE;
          end else fl_idx <= fl_idx + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  rd_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !q_byp && ev_hit && !q_write) |=> (rsp_valid && !mem_valid));
  // R2
  wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !q_byp && ev_hit && q_write && !q_wt)
      |=> (rsp_valid && !mem_valid && rsp_rdata == '0));
  // R3
  wt_hit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !q_byp && ev_hit && q_write && q_wt)
      |=> (mem_valid && mem_write && mem_addr == $past(q_addr) && mem_wdata == $past(q_wdata)));
  // R6
  evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !q_byp && !ev_hit && !q_write && ev_victim_dirty)
      |=> (mem_valid && mem_write));
  // R9
  flush_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready)
      |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));
  // R12
  mem_acc_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_acc |-> !$isunknown(mem_addr));

endmodule

// File: tb/dcache_ctrl_tb_top.sv
module dcache_ctrl_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cache_off = 1'b0, cfg_force_wt = 1'b0, flush_req = 1'b0;
  logic flush_done, req_ready, rsp_valid, mem_valid, mem_write;
  logic req_valid = 1'b0, req_write = 1'b0, req_pg_nocache = 1'b0, req_pg_wt = 1'b0;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, mem_wdata;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dcache_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cache_off(cfg_cache_off), .cfg_force_wt(cfg_force_wt),
    .flush_req(flush_req), .flush_done(flush_done), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_pg_nocache(req_pg_nocache), .req_pg_wt(req_pg_wt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  int cyc = 0, n_rd = 0, n_wr = 0, n_rsp = 0;
  int fd_cyc = -1, rsp_cyc = -1;
  logic [DW-1:0] mem_m [MW];
  logic [AW-1:0] rd_addr = '0;
  int rd_cnt = 0;
  logic [DW-1:0] exp_q [$];
  string req_q [$];
  bit prev_rsp = 1'b0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] init_word(input int a);
    return 32'hA000_0000 + DW'(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model: ready stalls every fourth cycle, read latency of two
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 4) != 3;
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem_m[i] <= init_word(i);
      rd_cnt <= 0;
      mem_rvalid <= 1'b0;
    end else begin
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          mem_m[mem_addr] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          rd_addr <= mem_addr;
          rd_cnt <= 2;
          n_rd <= n_rd + 1;
        end
      end else if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
      mem_rvalid <= (rd_cnt == 1);
      mem_rdata  <= mem_m[rd_addr];
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (flush_done) fd_cyc = cyc;
      if (rsp_valid) begin
        chk(!prev_rsp, "R11", "response pulse width", 32'(prev_rsp), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "response without request", rsp_rdata, '0);
        end else begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(rsp_rdata === e, r, "response data", rsp_rdata, e);
        end
        n_rsp++;
        rsp_cyc = cyc;
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit pnc, input bit pwt, input logic [DW-1:0] exp,
                        input int er, input int ew, input string rq);
    int r0, w0, tgt;
    r0 = n_rd; w0 = n_wr; tgt = n_rsp + 1;
    exp_q.push_back(exp); req_q.push_back(rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_pg_nocache = pnc; req_pg_wt = pwt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (n_rsp < tgt) @(negedge clk);
    @(negedge clk);
    chk(n_rd - r0 == er, rq, "memory reads", 32'(n_rd - r0), 32'(er));
    chk(n_wr - w0 == ew, rq, "memory writes", 32'(n_wr - w0), 32'(ew));
  endtask

  task automatic do_flush(input int ew, input string rq);
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
    chk(!flush_done, rq, "flush_done width", 32'(flush_done), 32'd0);
    chk(n_wr - w0 == ew, rq, "flush writes", 32'(n_wr - w0), 32'(ew));
    chk(n_rd == r0, rq, "flush reads", 32'(n_rd - r0), 32'd0);
  endtask

  always @(negedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "reset req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(flush_done === 1'b0, "R9", "reset flush_done", 32'(flush_done), 32'd0);
    chk(mem_valid === 1'b0, "R12", "reset mem_valid", 32'(mem_valid), 32'd0);

    // R4 read miss on clean empty line
    do_req(0, 10'h005, '0, 0, 0, init_word('h005), 4, 0, "R4");
    // R1 read hit
    do_req(0, 10'h006, '0, 0, 0, init_word('h006), 0, 0, "R1");
    // R2 write-back hit, memory untouched, then read back
    do_req(1, 10'h006, 32'h1111_1111, 0, 0, '0, 0, 0, "R2");
    chk(mem_m['h006] === init_word('h006), "R2", "memory after write-back hit",
        mem_m['h006], init_word('h006));
    do_req(0, 10'h006, '0, 0, 0, 32'h1111_1111, 0, 0, "R2");
    // R6 dirty victim written back, then fill
    do_req(0, 10'h045, '0, 0, 0, init_word('h045), 4, 4, "R6");
    chk(mem_m['h006] === 32'h1111_1111, "R6", "victim word in memory",
        mem_m['h006], 32'h1111_1111);
    // R3 / R8 page write-through hit
    do_req(1, 10'h046, 32'h2222_2222, 0, 1, '0, 0, 1, "R3");
    chk(mem_m['h046] === 32'h2222_2222, "R3", "write-through memory",
        mem_m['h046], 32'h2222_2222);
    // R8 global force write-through
    cfg_force_wt = 1'b1;
    do_req(1, 10'h047, 32'h3333_3333, 0, 0, '0, 0, 1, "R8");
    cfg_force_wt = 1'b0;
    chk(mem_m['h047] === 32'h3333_3333, "R8", "forced write-through memory",
        mem_m['h047], 32'h3333_3333);
    do_req(0, 10'h047, '0, 0, 0, 32'h3333_3333, 0, 0, "R8");
    // R5 write miss: one write then fill, then hit
    do_req(1, 10'h088, 32'h4444_4444, 0, 0, '0, 4, 1, "R5");
    do_req(0, 10'h088, '0, 0, 0, 32'h4444_4444, 0, 0, "R5");
    // R7 bypass by page bit and by global bit
    do_req(0, 10'h089, '0, 1, 0, init_word('h089), 1, 0, "R7");
    do_req(1, 10'h08A, 32'h5555_5555, 1, 0, '0, 0, 1, "R7");
    chk(mem_m['h08A] === 32'h5555_5555, "R7", "bypass write memory",
        mem_m['h08A], 32'h5555_5555);
    do_req(0, 10'h08A, '0, 0, 0, init_word('h08A), 0, 0, "R7");
    cfg_cache_off = 1'b1;
    do_req(0, 10'h046, '0, 0, 0, 32'h2222_2222, 1, 0, "R7");
    cfg_cache_off = 1'b0;
    // R9 flush with two dirty lines
    do_req(1, 10'h0C0, 32'h0000_0009, 0, 0, '0, 4, 1, "R5");
    do_req(1, 10'h0C1, 32'h6666_6666, 0, 0, '0, 0, 0, "R2");
    do_req(1, 10'h046, 32'h7777_7777, 0, 0, '0, 0, 0, "R2");
    do_flush(8, "R9");
    chk(mem_m['h0C1] === 32'h6666_6666, "R9", "flushed word line 0",
        mem_m['h0C1], 32'h6666_6666);
    chk(mem_m['h046] === 32'h7777_7777, "R9", "flushed word line 1",
        mem_m['h046], 32'h7777_7777);
    do_req(0, 10'h046, '0, 0, 0, 32'h7777_7777, 4, 0, "R9");
    // R10 flush and request in the same cycle
    do_req(0, 10'h0C2, '0, 0, 0, init_word('h0C2), 4, 0, "R4");
    do_req(1, 10'h0C2, 32'h8888_8888, 0, 0, '0, 0, 0, "R2");
    begin
      int r0, w0, tgt;
      r0 = n_rd; w0 = n_wr; tgt = n_rsp + 1; fd_cyc = -1;
      exp_q.push_back(init_word('h0C3)); req_q.push_back("R10");
      @(negedge clk);
      flush_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h0C3;
      req_pg_nocache = 1'b0; req_pg_wt = 1'b0;
      #1;
      chk(req_ready === 1'b0, "R10", "req_ready with flush", 32'(req_ready), 32'd0);
      @(negedge clk); flush_req = 1'b0;
      while (!req_ready) @(negedge clk);
      @(negedge clk); req_valid = 1'b0;
      while (n_rsp < tgt) @(negedge clk);
      @(negedge clk);
      chk(fd_cyc >= 0 && fd_cyc < rsp_cyc, "R10", "flush_done before response",
          32'(fd_cyc), 32'(rsp_cyc));
      chk(n_wr - w0 == 4, "R10", "flush writes", 32'(n_wr - w0), 32'd4);
      chk(n_rd - r0 == 4, "R10", "refill reads", 32'(n_rd - r0), 32'd4);
      chk(mem_m['h0C2] === 32'h8888_8888, "R10", "flushed word",
          mem_m['h0C2], 32'h8888_8888);
    end
    chk(exp_q.size() == 0, "R11", "responses outstanding", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule